// File: doc/BRIEF.md
# ADC Test Pattern Monitor

The block watches the stream of 14-bit sample words from an ADC and decides, sample by sample, whether the stream is a clean copy of either of two known test patterns. One pattern toggles between 0x2AAA and 0x1555. The other is a 14-bit ramp that rises by one each sample. Both checks run side by side on every ADC clock, so the block never has to find a starting point or know which pattern the converter is sending.

Each pattern has a sticky OK flag. A single mismatch drops the flag. Only a set command from the register side raises it again. A link test therefore works in three steps. First, point the converter at a pattern. Second, issue a set command. Third, read the flags some time later.

A second function measures the ADC clock against the read clock. It counts ADC clock edges over a fixed window of read-clock cycles and holds the last complete count for software to read. With a 100 MHz read clock and a window of 1000 cycles, the count divided by ten gives the ADC frequency in MHz.

Two sets of logic cross between the clock domains:
- the set command, carried as a toggle into the ADC domain;
- the flags and a Gray-coded edge counter, synchronised into the read domain.

Two small state machines sequence the block:
- **Pattern checker.** `CHK_PRIME` loads a reference sample without comparing it. `CHK_RUN` compares every sample with the one before it. A set command forces `CHK_PRIME` (transition *rearm*). `CHK_PRIME` always moves to `CHK_RUN` on the next sample (transition *primed*). `CHK_RUN` stays in `CHK_RUN` (transition *track*).
- **Frequency window.** `WIN_COUNT` advances the window counter. When the counter reaches `WINDOW-2` it moves to `WIN_LATCH` (transition *window_full*). `WIN_LATCH` stores the edge count for the window and returns to `WIN_COUNT` (transition *restart*).

Top module: `adc_pattern_monitor`

## Requirements
- R1: After reset, `check_flags` is 2'b00 and `freq_count` is 0.
- R2: The toggle check uses `check_flags[0]`. In a stream where 0x2AAA and 0x1555 alternate on consecutive samples, the flag stays 1. Any compared sample that breaks the alternation clears it.
- R3: The ramp check uses `check_flags[1]`. In a stream where each sample equals the previous one plus one, modulo 2^14, the flag stays 1. The step from 0x3FFF to 0x0000 counts as correct. Any other step clears the flag.
- R4: A cleared flag stays 0 even after the pattern becomes correct again. Only a set command raises it.
- R5: A one-cycle pulse on `set_flags` in the read domain sets both flags to 1. Samples taken before the command has effect play no part in later results. The first sample after the command is used only as the reference.
- R6: Both checks run on every sample in parallel. A clean toggle stream leaves the ramp flag at 0, and a clean ramp stream leaves the toggle flag at 0.
- R7: `freq_count` reports the number of ADC clock edges counted in the last complete window of `WINDOW` read-clock cycles. It changes only at window ends, and each window starts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Read (register side) clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| adc_clk | input | 1 | ADC sample clock |
| adc_rst_n | input | 1 | Active-low reset, ADC domain |
| adc_sample | input | 14 | Sample word, one per `adc_clk` cycle |
| set_flags | input | 1 | One-cycle set command (read domain) |
| check_flags | output | 2 | Bit 1: ramp OK, bit 0: toggle OK (read domain) |
| freq_count | output | 16 | ADC edges counted in the last window |

## Verification
The set command reaches the flags within about four ADC cycles plus three read cycles. A mismatch reaches `check_flags` within one ADC cycle plus two read cycles. The bench therefore waits 40 read cycles after each command or injected error before it samples the flags, and it samples them on the falling edge of `rd_clk`. A new `freq_count` is due one window after a full window has run at the new ADC rate. The bench waits 2500 read cycles after each change of ADC period and accepts a deviation of two edges, which covers the uncertainty of the synchroniser.

// File: rtl/adc_pat_pkg.sv
package adc_pat_pkg;
    typedef enum logic {CHK_PRIME, CHK_RUN} chk_state_t;
    typedef enum logic {WIN_COUNT, WIN_LATCH} win_state_t;
endpackage

// File: rtl/adc_sync_bits.sv
module adc_sync_bits #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/adc_pat_check.sv
module adc_pat_check
    import adc_pat_pkg::*;
#(
    parameter int SW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample,
    input  logic          rearm,
    output logic [1:0]    flags
);
    localparam logic [SW-1:0] TOG_A = {(SW/2){2'b10}};
    localparam logic [SW-1:0] TOG_B = ~TOG_A;

    chk_state_t    state, state_nx;
    logic [SW-1:0] prev;
    logic          tog_bad, ramp_bad;

    always_comb begin
        tog_bad  = !(((prev == TOG_A) && (sample == TOG_B)) ||
                     ((prev == TOG_B) && (sample == TOG_A)));
        ramp_bad = (sample != SW'(prev + 1'b1));
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CHK_PRIME: state_nx = CHK_RUN;
            CHK_RUN:   state_nx = CHK_RUN;
        endcase
        if (rearm) state_nx = CHK_PRIME;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CHK_PRIME;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= 2'b00;
            prev  <= '0;
        end else begin
            prev <= sample;
            if (rearm) begin
                flags <= 2'b11;
            end else if (state == CHK_RUN) begin
                if (tog_bad)  flags[0] <= 1'b0;
                if (ramp_bad) flags[1] <= 1'b0;
            end
        end
    end

    AST_REARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (flags == 2'b11) && (state == CHK_PRIME)); // R5
    AST_PRIME_NO_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CHK_PRIME) && !rearm |=> $stable(flags)); // R5
    AST_TOG_RISE_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(rearm)); // R4
    AST_RAMP_RISE_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(rearm)); // R4
    AST_RAMP_WRAP_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CHK_RUN) && !rearm && flags[1] && (prev == '1) && (sample == '0)
        |=> flags[1]); // R3
endmodule

// File: rtl/adc_freq_meter.sv
module adc_freq_meter
    import adc_pat_pkg::*;
#(
    parameter int WINDOW = 1000,
    parameter int CW     = 16
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          adc_clk,
    input  logic          adc_rst_n,
    output logic [CW-1:0] count
);
    localparam int WCW = $clog2(WINDOW);

    logic [CW-1:0]  adc_bin, adc_gray, gray_rd, bin_rd, snap;
    logic [WCW-1:0] win_cnt;
    win_state_t     state, state_nx;

    always_ff @(posedge adc_clk or negedge adc_rst_n) begin
        if (!adc_rst_n) begin
            adc_bin  <= '0;
            adc_gray <= '0;
        end else begin
            adc_bin  <= adc_bin + 1'b1;
            adc_gray <= (adc_bin + 1'b1) ^ ((adc_bin + 1'b1) >> 1);
        end
    end

    adc_sync_bits #(.W(CW), .STAGES(2)) u_gray_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(adc_gray), .q(gray_rd)
    );

    always_comb begin
        bin_rd[CW-1] = gray_rd[CW-1];
        for (int i = CW - 2; i >= 0; i--) bin_rd[i] = bin_rd[i+1] ^ gray_rd[i];
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WIN_COUNT: if (win_cnt == WCW'(WINDOW - 2)) state_nx = WIN_LATCH;
            WIN_LATCH: state_nx = WIN_COUNT;
        endcase
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) state <= WIN_COUNT;
        else           state <= state_nx;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            win_cnt <= '0;
            count   <= '0;
            snap    <= '0;
        end else begin
            unique case (state)
                WIN_COUNT: win_cnt <= win_cnt + 1'b1;
                WIN_LATCH: begin
                    win_cnt <= '0;
                    count   <= bin_rd - snap;
                    snap    <= bin_rd;
                end
            endcase
        end
    end

    AST_WINDOW_BOUND: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        win_cnt < WCW'(WINDOW)); // R7
    AST_COUNT_AT_END: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !$stable(count) |-> $past(state == WIN_LATCH)); // R7
    AST_LATCH_RESTART: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (state == WIN_LATCH) |=> (win_cnt == '0) && (state == WIN_COUNT)); // R7
endmodule

// File: rtl/adc_pattern_monitor.sv
module adc_pattern_monitor #(
    parameter int SAMPLE_W = 14,
    parameter int WINDOW   = 1000,
    parameter int CNT_W    = 16
) (
    input  logic                rd_clk,
    input  logic                rd_rst_n,
    input  logic                adc_clk,
    input  logic                adc_rst_n,
    input  logic [SAMPLE_W-1:0] adc_sample,
    input  logic                set_flags,
    output logic [1:0]          check_flags,
    output logic [CNT_W-1:0]    freq_count
);
    logic       set_tgl, set_tgl_adc, set_tgl_d, rearm_adc;
    logic [1:0] flags_adc;

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n)      set_tgl <= 1'b0;
        else if (set_flags) set_tgl <= ~set_tgl;
    end

    adc_sync_bits #(.W(1), .STAGES(2)) u_set_sync (
        .clk(adc_clk), .rst_n(adc_rst_n), .d(set_tgl), .q(set_tgl_adc)
    );

    always_ff @(posedge adc_clk or negedge adc_rst_n) begin
        if (!adc_rst_n) set_tgl_d <= 1'b0;
        else            set_tgl_d <= set_tgl_adc;
    end

    assign rearm_adc = set_tgl_adc ^ set_tgl_d;

    adc_pat_check #(.SW(SAMPLE_W)) u_check (
        .clk(adc_clk), .rst_n(adc_rst_n), .sample(adc_sample),
        .rearm(rearm_adc), .flags(flags_adc)
    );

    adc_sync_bits #(.W(2), .STAGES(2)) u_flag_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(flags_adc), .q(check_flags)
    );

    adc_freq_meter #(.WINDOW(WINDOW), .CW(CNT_W)) u_freq (
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .adc_clk(adc_clk),
        .adc_rst_n(adc_rst_n), .count(freq_count)
    );

    AST_SET_TOGGLES: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        set_flags |=> (set_tgl != $past(set_tgl))); // R5
    AST_REARM_ONESHOT: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
        rearm_adc |=> !rearm_adc); // R5
endmodule

// File: tb/adc_pattern_monitor_test.sv
`timescale 1ns/1ps
module adc_pattern_monitor_test;
    logic        rd_clk = 0, adc_clk = 0, rst_n = 0, set_flags = 0;
    logic [13:0] smp = 0;
    logic [1:0]  flags;
    logic [15:0] fcnt;
    realtime     adc_half = 2.5;
    int          checks = 0, failures = 0, mode = 2, inject = 0, seen = 0;
    bit          done = 0;

    adc_pattern_monitor uut (
        .rd_clk(rd_clk), .rd_rst_n(rst_n), .adc_clk(adc_clk), .adc_rst_n(rst_n),
        .adc_sample(smp), .set_flags(set_flags), .check_flags(flags), .freq_count(fcnt)
    );

    always #2 rd_clk = ~rd_clk;
    always #(adc_half) adc_clk = ~adc_clk;

    // mode 0 toggle, 1 ramp, 2 random, 3 ramp that later gets a glitch
    always @(negedge adc_clk) begin
        if (inject != seen) begin
            seen = inject;
            smp <= smp + 14'd7;
        end else if (mode == 0) smp <= (smp == 14'h2AAA) ? 14'h1555 : 14'h2AAA;
        else if (mode == 2)     smp <= 14'($urandom);
        else                    smp <= smp + 14'd1;
    end

    function automatic logic [1:0] exp_flags(input int m);
        case (m)
            0:       return 2'b01;
            1:       return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic wait_rd(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_near(input string req, input int act, input int expv);
        checks++;
        if (act < expv - 2 || act > expv + 2) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic pulse_set();
        @(negedge rd_clk) set_flags = 1;
        @(negedge rd_clk) set_flags = 0;
        wait_rd(40);
    endtask

    task automatic glitch();
        inject++;
        wait_rd(40);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        wait_rd(5);
        rst_n = 1;
        wait_rd(5);
        chk("R1 flags", flags, 2'b00);
        chk("R1 freq", fcnt, 16'd0);

        mode = 0; pulse_set();
        chk("R2 toggle ok", flags, 2'b01);
        chk("R6 ramp flag low on toggle", flags[1], 1'b0);
        glitch();
        chk("R2 toggle break", flags[0], 1'b0);
        wait_rd(100);
        chk("R4 toggle sticky", flags[0], 1'b0);

        // random junk before the set command; ramp begins as the command is issued
        mode = 2; wait_rd(20);
        mode = 1; pulse_set();
        chk("R5 history ignored", flags, 2'b10);
        chk("R6 toggle flag low on ramp", flags[0], 1'b0);

        // directed wrap 0x3FFF -> 0x0000
        @(negedge adc_clk) smp = 14'h3FF0;
        wait_rd(5);
        pulse_set();
        wait_rd(40);
        chk("R3 ramp through wrap", flags[1], 1'b1);
        glitch();
        chk("R3 ramp step error", flags[1], 1'b0);
        wait_rd(200);
        chk("R4 ramp sticky", flags[1], 1'b0);
        pulse_set();
        chk("R5 set again", flags, 2'b10);

        for (int i = 0; i < 12; i++) begin
            int m;
            m = int'($urandom_range(0, 3));
            mode = (m == 3) ? 1 : m;
            pulse_set();
            if (m == 3) glitch();
            wait_rd(30);
            chk($sformatf("R6 random mode %0d", m), flags, exp_flags(m));
        end

        adc_half = 2.5; wait_rd(2500);
        chk_near("R7 freq 200MHz", int'(fcnt), 800);
        adc_half = 4.0; wait_rd(2500);
        chk_near("R7 freq 125MHz", int'(fcnt), 500);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule